// File: doc/BRIEF.md
# Serial Register Port with Shared Data Line

This block is the device side of a two-wire, half-duplex register port of the kind a motion sensor presents to its host controller. The host supplies the serial clock and shares one bidirectional data line with the device. Every transaction has sixteen clocks. The first byte carries a direction flag and a 7-bit register address. The second byte carries data, which the host writes or the device returns.

The serial clock is brought into the system clock domain and decoded there. The block owns two registers: a configuration register with soft-reset, power-down, LED shutter and forced-awake controls, and a read-only status register. All other registers in the valid window are reached through a plain strobe-and-data interface to the surrounding logic. A per-transaction watchdog returns the port to idle if a transaction stalls part-way through, so that a host which has lost step can resynchronise. The data line is modelled as separate input, output and output-enable signals.

Top module: `tw_regport`

## Requirements
- R1: A transaction is 16 rising serial-clock edges: a direction flag (1 = write, 0 = read), then address bits 6..0, then data bits 7..0, each field most significant bit first. The block samples data on rising edges.
- R2: On a read, `sdio_oe` goes high after the 8th rising edge and `sdio_out` presents data bit 7. Each following bit is presented after a falling edge, so the host reads bits 7..0 on rising edges 9 to 16.
- R3: After the 16th rising edge of a read, the block keeps driving bit 0 until the next falling edge, then drops `sdio_oe`.
- R4: If the 16th rising edge has not come TIMEOUT_CYC system clocks after the first serial-clock edge of a transaction, the port returns to idle and releases the line, and the next transaction decodes from its first bit.
- R5: An address outside BASE_ADDR .. BASE_ADDR+NUM_REGS-1 is invalid. Writing to it changes no register and gives no write strobe. Reading it returns 0x00.
- R6: The configuration register is at BASE_ADDR (0x40) and resets to 0x00. It stores bit 6 (power down, `pwr_down_o`), bit 5 (LED shutter, `led_shutter_o`) and bit 0 (forced awake, `stay_awake_o`). Bits 7 and 4..1 read back as 0.
- R7: A configuration write with bit 7 set, outside power down, gives a single-cycle `soft_rst_o` pulse. The write's other bits are stored as in R6.
- R8: While bit 6 is set, a configuration write updates only bit 6 and gives no soft reset. Reads do not drive the line (`sdio_oe` stays 0). The watchdog count is frozen.
- R9: The status register at BASE_ADDR+1 (0x41) reads {PRODUCT_ID = 3'b010, 4'b0000, awake_i}, which is 0x41 when awake.
- R10: Addresses BASE_ADDR+2 .. BASE_ADDR+NUM_REGS-1 (0x42..0x4B) go to the surrounding logic. A write gives an `ext_wr_o` pulse with `ext_addr_o` and `ext_wdata_o` at the 16th rising edge. A read gives an `ext_rd_o` pulse after the 8th rising edge and returns `ext_rdata_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Host serial clock, asynchronous, idles high |
| sdio_in | input | 1 | Data line as seen at the pad |
| sdio_out | output | 1 | Data the block drives onto the line |
| sdio_oe | output | 1 | Output enable for the data line |
| awake_i | input | 1 | Awake state reported in status bit 0 |
| pwr_down_o | output | 1 | Configuration bit 6 |
| led_shutter_o | output | 1 | Configuration bit 5 |
| stay_awake_o | output | 1 | Configuration bit 0 |
| soft_rst_o | output | 1 | One-cycle soft reset request |
| ext_rd_o | output | 1 | Read strobe to surrounding registers |
| ext_wr_o | output | 1 | Write strobe to surrounding registers |
| ext_addr_o | output | 7 | Register address for the strobes |
| ext_wdata_o | output | 8 | Write data |
| ext_rdata_i | input | 8 | Read data, valid in the ext_rd_o cycle |

## Verification
A bit counter that is off by one shows at once as a read value shifted by one place, or as a write that lands at a shifted address. Both appear at the end of the same 16-clock transaction. A watchdog that fails to fire leaves the port out of step, so the read-back after a deliberately broken transaction comes back wrong. A release that comes too early or too late shows as `sdio_oe` being wrong just before the 16th rising edge or just after the next falling edge. A configuration register that ignores the power-down mask is caught by the next read-back of 0x40 once power-down is cleared.

// File: rtl/tw_port_pkg.sv
package tw_port_pkg;
   localparam int ADDR_W      = 7;
   localparam int DATA_W      = 8;
   localparam int FRAME_BITS  = 1 + ADDR_W + DATA_W;
   localparam int HDR_LAST    = ADDR_W;          // index of last header rise
   localparam int FRAME_LAST  = FRAME_BITS - 1;  // index of last frame rise
   localparam int CNT_W       = $clog2(FRAME_BITS);
   localparam int CFG_RST_BIT = 7;
   localparam int CFG_PD_BIT  = 6;
   localparam logic [DATA_W-1:0] CFG_KEEP_MASK = 8'h61;
endpackage

// File: rtl/tw_sck_edge.sv
module tw_sck_edge #(
   parameter int STAGES = 2
)(
   input  logic clk,
   input  logic rst_n,
   input  logic sck_i,
   output logic rise_o,
   output logic fall_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tw_sck_edge: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES:0] pipe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '1;
      else        pipe_q <= {pipe_q[STAGES-1:0], sck_i};
   end

   assign rise_o =  pipe_q[STAGES-1] & ~pipe_q[STAGES];
   assign fall_o = ~pipe_q[STAGES-1] &  pipe_q[STAGES];
endmodule

// File: rtl/tw_watchdog.sv
module tw_watchdog #(
   parameter int unsigned LIMIT = 1000,
   parameter int          CW    = 10
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear_i,
   input  logic          run_i,
   output logic          expire_o,
   output logic [CW-1:0] count_o
);
   generate
      if (LIMIT == 0) begin : g_off
         assign expire_o = 1'b0;
         assign count_o  = '0;
      end else begin : g_on
         if (CW < $clog2(LIMIT + 1)) begin : g_bad_cw
            $error("tw_watchdog: CW too narrow for LIMIT");
         end
         logic [CW-1:0] cnt_q;
         assign expire_o = run_i && !clear_i && (cnt_q == CW'(LIMIT - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        cnt_q <= '0;
            else if (clear_i)  cnt_q <= '0;
            else if (expire_o) cnt_q <= '0;
            else if (run_i)    cnt_q <= cnt_q + 1'b1;
         end
         assign count_o = cnt_q;
      end
   endgenerate
endmodule

// File: rtl/tw_cfg_regs.sv
module tw_cfg_regs import tw_port_pkg::*; #(
   parameter logic [2:0] PRODUCT_ID = 3'b010
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              awake_i,
   output logic [DATA_W-1:0] cfg_o,
   output logic [DATA_W-1:0] status_o,
   output logic              soft_rst_o
);
   logic [DATA_W-1:0] cfg_q;
   logic              pulse_q;
   logic              pd;

   assign pd = cfg_q[CFG_PD_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= 1'b0;
         if (wr_i) begin
            if (pd) begin
               cfg_q[CFG_PD_BIT] <= wdata_i[CFG_PD_BIT];
            end else begin
               cfg_q   <= wdata_i & CFG_KEEP_MASK;
               pulse_q <= wdata_i[CFG_RST_BIT];
            end
         end
      end
   end

   assign cfg_o      = cfg_q;
   assign status_o   = {PRODUCT_ID, 4'b0000, awake_i};
   assign soft_rst_o = pulse_q;
endmodule

// File: rtl/tw_regport.sv
module tw_regport import tw_port_pkg::*; #(
   parameter int unsigned TIMEOUT_CYC = 2_160_000,
   parameter int          SYNC_STAGES = 2,
   parameter logic [6:0]  BASE_ADDR   = 7'h40,
   parameter int          NUM_REGS    = 12,
   parameter logic [2:0]  PRODUCT_ID  = 3'b010
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck,
   input  logic              sdio_in,
   output logic              sdio_out,
   output logic              sdio_oe,
   input  logic              awake_i,
   output logic              pwr_down_o,
   output logic              led_shutter_o,
   output logic              stay_awake_o,
   output logic              soft_rst_o,
   output logic              ext_rd_o,
   output logic              ext_wr_o,
   output logic [ADDR_W-1:0] ext_addr_o,
   output logic [DATA_W-1:0] ext_wdata_o,
   input  logic [DATA_W-1:0] ext_rdata_i
);
   localparam int WD_W   = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC + 1) : 1;
   localparam int EXT_LO = int'(BASE_ADDR) + 2;
   localparam int EXT_HI = int'(BASE_ADDR) + NUM_REGS - 1;

   generate
      if (NUM_REGS < 2) begin : g_bad_num
         $error("tw_regport: NUM_REGS must cover the two local registers");
      end
      if (int'(BASE_ADDR) + NUM_REGS > 128) begin : g_bad_range
         $error("tw_regport: register window exceeds the address space");
      end
   endgenerate

   logic              sck_rise, sck_fall;
   logic [CNT_W-1:0]  bit_cnt_q;
   logic [DATA_W-1:0] hdr_q, wbyte_q, obyte_q;
   logic              active_q, oe_q, hold_q;
   logic              wd_clear, wd_run, wd_expire;
   logic [WD_W-1:0]   wd_count;
   logic [DATA_W-1:0] hdr_full, wdata_full, cfg_val, status_val, rd_val;
   logic [ADDR_W-1:0] cur_addr;
   logic              cur_read, hdr_done, frame_done;
   logic              cfg_hit, stat_hit, ext_hit, rd_go, wr_go;

   tw_sck_edge #(.STAGES(SYNC_STAGES)) edge_i (
      .clk(clk), .rst_n(rst_n), .sck_i(sck), .rise_o(sck_rise), .fall_o(sck_fall));

   assign hdr_full   = {hdr_q[DATA_W-2:0], sdio_in};
   assign wdata_full = {wbyte_q[DATA_W-2:0], sdio_in};
   assign hdr_done   = sck_rise && (bit_cnt_q == CNT_W'(HDR_LAST));
   assign frame_done = sck_rise && (bit_cnt_q == CNT_W'(FRAME_LAST));
   assign cur_addr   = hdr_done ? hdr_full[ADDR_W-1:0] : hdr_q[ADDR_W-1:0];
   assign cur_read   = hdr_done ? ~hdr_full[DATA_W-1] : ~hdr_q[DATA_W-1];

   assign cfg_hit  = (cur_addr == BASE_ADDR);
   assign stat_hit = (cur_addr == BASE_ADDR + 7'd1);
   assign ext_hit  = (int'(cur_addr) >= EXT_LO) && (int'(cur_addr) <= EXT_HI);

   assign rd_go = hdr_done && cur_read && !pwr_down_o && !wd_expire;
   assign wr_go = frame_done && !cur_read && !wd_expire;

   // watchdog: restarted by any edge while no bit has been taken
   assign wd_clear = (sck_rise || sck_fall) && (bit_cnt_q == '0);
   assign wd_run   = active_q && !pwr_down_o;

   tw_watchdog #(.LIMIT(TIMEOUT_CYC), .CW(WD_W)) wd_i (
      .clk(clk), .rst_n(rst_n), .clear_i(wd_clear), .run_i(wd_run),
      .expire_o(wd_expire), .count_o(wd_count));

   tw_cfg_regs #(.PRODUCT_ID(PRODUCT_ID)) cfg_i (
      .clk(clk), .rst_n(rst_n), .wr_i(wr_go && cfg_hit), .wdata_i(wdata_full),
      .awake_i(awake_i), .cfg_o(cfg_val), .status_o(status_val), .soft_rst_o(soft_rst_o));

   always_comb begin
      rd_val = '0;
      if (cfg_hit)       rd_val = cfg_val;
      else if (stat_hit) rd_val = status_val;
      else if (ext_hit)  rd_val = ext_rdata_i;
   end

   // frame position and shift registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt_q <= '0;
         active_q  <= 1'b0;
         hdr_q     <= '0;
         wbyte_q   <= '0;
      end else if (wd_expire) begin
         bit_cnt_q <= '0;
         active_q  <= 1'b0;
      end else begin
         if (frame_done)    active_q <= 1'b0;
         else if (wd_clear) active_q <= 1'b1;
         if (sck_rise) begin
            bit_cnt_q <= frame_done ? '0 : bit_cnt_q + 1'b1;
            if (bit_cnt_q <= CNT_W'(HDR_LAST)) hdr_q   <= hdr_full;
            else                               wbyte_q <= wdata_full;
         end
      end
   end

   // line direction and read shifter
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_q    <= 1'b0;
         hold_q  <= 1'b0;
         obyte_q <= '0;
      end else if (wd_expire) begin
         oe_q   <= 1'b0;
         hold_q <= 1'b0;
      end else if (rd_go) begin
         oe_q    <= 1'b1;
         hold_q  <= 1'b0;
         obyte_q <= rd_val;
      end else if (frame_done && oe_q) begin
         hold_q <= 1'b1;
      end else if (sck_fall && oe_q) begin
         if (hold_q) begin
            oe_q   <= 1'b0;
            hold_q <= 1'b0;
         end else if (bit_cnt_q >= CNT_W'(HDR_LAST + 2)) begin
            obyte_q <= {obyte_q[DATA_W-2:0], 1'b0};
         end
      end
   end

   assign sdio_out      = obyte_q[DATA_W-1];
   assign sdio_oe       = oe_q;
   assign pwr_down_o    = cfg_val[CFG_PD_BIT];
   assign led_shutter_o = cfg_val[5];
   assign stay_awake_o  = cfg_val[0];
   assign ext_rd_o      = rd_go && ext_hit;
   assign ext_wr_o      = wr_go && ext_hit;
   assign ext_addr_o    = cur_addr;
   assign ext_wdata_o   = wdata_full;
endmodule

// File: rtl/tw_regport_chk.sv
module tw_regport_chk #(
   parameter int         CW   = 8,
   parameter logic [6:0] BASE = 7'h40,
   parameter int         NUM  = 12
)(
   input logic          clk,
   input logic          rst_n,
   input logic          pwr_down,
   input logic          sdio_oe,
   input logic          soft_rst,
   input logic          wd_clear,
   input logic          wd_expire,
   input logic [CW-1:0] wd_count,
   input logic [3:0]    bit_cnt,
   input logic          hdr_done,
   input logic          sck_fall,
   input logic          ext_wr,
   input logic          ext_rd,
   input logic [6:0]    ext_addr
);
   // R8
   pd_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_down |-> !sdio_oe);
   // R8
   pd_wd_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_down && !wd_clear) |=> $stable(wd_count));
   // R4
   wd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wd_expire |=> (bit_cnt == 4'd0) && !sdio_oe);
   // R7
   soft_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> !soft_rst);
   // R10
   ext_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_wr |-> (int'(ext_addr) >= int'(BASE) + 2) && (int'(ext_addr) < int'(BASE) + NUM));
   // R10
   ext_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ext_wr && ext_rd));
   // R2
   drive_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdio_oe) |-> $past(hdr_done));
   // R3
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sdio_oe) |-> $past(sck_fall || wd_expire));
endmodule

bind tw_regport tw_regport_chk #(.CW(WD_W), .BASE(BASE_ADDR), .NUM(NUM_REGS)) chk_i (
   .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down_o), .sdio_oe(sdio_oe),
   .soft_rst(soft_rst_o), .wd_clear(wd_clear), .wd_expire(wd_expire),
   .wd_count(wd_count), .bit_cnt(bit_cnt_q), .hdr_done(hdr_done),
   .sck_fall(sck_fall), .ext_wr(ext_wr_o), .ext_rd(ext_rd_o), .ext_addr(ext_addr_o));

// File: tb/tw_regport_tb_top.sv
module tw_regport_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 8;
   localparam int GAP        = 20;
   localparam int TOUT       = 400;

   logic clk = 1'b0, rst_n = 1'b0, sck = 1'b1, sdio_in = 1'b1, awake_i = 1'b1;
   logic sdio_out, sdio_oe, pwr_down_o, led_shutter_o, stay_awake_o, soft_rst_o;
   logic ext_rd_o, ext_wr_o;
   logic [6:0] ext_addr_o;
   logic [7:0] ext_wdata_o, ext_rdata_i;
   logic [7:0] ext_mem [16];
   logic [7:0] exp_ext [16];
   logic [7:0] exp_cfg = 8'h00;
   int tests = 0, fails = 0, soft_seen = 0, soft_exp = 0, ext_wr_seen = 0;
   logic pend_release = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tw_regport #(.TIMEOUT_CYC(TOUT)) dut_i (
      .clk(clk), .rst_n(rst_n), .sck(sck), .sdio_in(sdio_in), .sdio_out(sdio_out),
      .sdio_oe(sdio_oe), .awake_i(awake_i), .pwr_down_o(pwr_down_o),
      .led_shutter_o(led_shutter_o), .stay_awake_o(stay_awake_o), .soft_rst_o(soft_rst_o),
      .ext_rd_o(ext_rd_o), .ext_wr_o(ext_wr_o), .ext_addr_o(ext_addr_o),
      .ext_wdata_o(ext_wdata_o), .ext_rdata_i(ext_rdata_i));

   // surrounding register model (the logic the port serves)
   assign ext_rdata_i = ext_mem[ext_addr_o[3:0]];
   always @(posedge clk) begin
      if (ext_wr_o) begin
         ext_mem[ext_addr_o[3:0]] <= ext_wdata_o;
         ext_wr_seen <= ext_wr_seen + 1;
      end
      if (soft_rst_o) soft_seen <= soft_seen + 1;
   end

   task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_rd(input logic [6:0] a);
      if (a == 7'h40) return exp_cfg;
      if (a == 7'h41) return {3'b010, 4'b0000, awake_i};
      if (a >= 7'h42 && a <= 7'h4B) return exp_ext[a[3:0]];
      return 8'h00;
   endfunction

   // host model of one full transaction
   task automatic xfer(input logic rd, input logic [6:0] a, input logic [7:0] wd,
                       output logic [7:0] rv, output logic drv);
      logic [15:0] frame;
      frame = {~rd, a, wd};
      rv = '0;
      drv = 1'b1;
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         sck = 1'b0;
         if (!(rd && i >= 8)) sdio_in = frame[15-i];
         repeat (HALF) @(negedge clk);
         if (i == 0 && pend_release) begin
            // R3: released after the falling edge that follows a read
            check(!sdio_oe, "R3 release", {31'b0, sdio_oe}, 0);
            pend_release = 1'b0;
         end
         if (rd && i >= 8) begin
            drv = drv & sdio_oe;
            rv = {rv[6:0], sdio_out};
         end
         sck = 1'b1;
         repeat (HALF) @(negedge clk);
      end
      if (rd && drv) begin
         // R3: D0 still held after the last rising edge
         check(sdio_oe === 1'b1, "R3 hold", {31'b0, sdio_oe}, 1);
         pend_release = 1'b1;
      end
      repeat (GAP) @(negedge clk);
   endtask

   task automatic partial(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); sck = 1'b0; sdio_in = i[0];
         repeat (HALF) @(negedge clk); sck = 1'b1;
         repeat (HALF) @(negedge clk);
      end
   endtask

   task automatic model_write(input logic [6:0] a, input logic [7:0] wd);
      if (a == 7'h40) begin
         if (exp_cfg[6]) exp_cfg[6] = wd[6];
         else begin
            exp_cfg = wd & 8'h61;
            if (wd[7]) soft_exp++;
         end
      end else if (a >= 7'h42 && a <= 7'h4B) begin
         exp_ext[a[3:0]] = wd;
      end
   endtask

   task automatic wr(input logic [6:0] a, input logic [7:0] wd);
      logic [7:0] rv; logic drv;
      xfer(1'b0, a, wd, rv, drv);
      model_write(a, wd);
   endtask

   task automatic rd_chk(input logic [6:0] a, input string req);
      logic [7:0] rv; logic drv;
      xfer(1'b1, a, 8'h00, rv, drv);
      if (exp_cfg[6]) check(!drv, req, {31'b0, drv}, 0);
      else            check(drv && rv == exp_rd(a), req, {23'b0, drv, rv}, {24'h1, exp_rd(a)});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog run timeout actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int wcnt;
      void'($urandom(32'h5eed_2620));
      for (int k = 0; k < 16; k++) begin
         ext_mem[k] = 8'h00;
         exp_ext[k] = 8'h00;
      end
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R6: reset state
      check(!sdio_oe && !pwr_down_o && !led_shutter_o && !stay_awake_o && !soft_rst_o,
            "R6 reset outputs", {27'b0, sdio_oe, pwr_down_o, led_shutter_o, stay_awake_o, soft_rst_o}, 0);
      rd_chk(7'h40, "R6 cfg reset");
      rd_chk(7'h41, "R9 status awake");    // also R2 read path
      awake_i = 1'b0;
      rd_chk(7'h41, "R9 status asleep");
      awake_i = 1'b1;

      // R6: masked storage
      wr(7'h40, 8'h3F);
      check(led_shutter_o && stay_awake_o && !pwr_down_o, "R6 cfg outputs",
            {29'b0, pwr_down_o, led_shutter_o, stay_awake_o}, 3);
      rd_chk(7'h40, "R6 cfg readback");

      // R7: soft reset
      wr(7'h40, 8'h81);
      check(soft_seen == 1, "R7 soft pulse", soft_seen, 1);
      rd_chk(7'h40, "R7 other bits written");

      // R10 / R1: surrounding registers at window edges
      wr(7'h42, 8'h80);
      wr(7'h4B, 8'h7F);
      rd_chk(7'h42, "R10 low edge");
      rd_chk(7'h4B, "R10 high edge");

      // R5: invalid addresses
      wcnt = ext_wr_seen;
      wr(7'h77, 8'hFF);
      wr(7'h4C, 8'hFF);
      wr(7'h3F, 8'hFF);
      check(ext_wr_seen == wcnt, "R5 no strobe", ext_wr_seen, wcnt);
      rd_chk(7'h40, "R5 cfg untouched");
      rd_chk(7'h00, "R5 read zero");
      rd_chk(7'h4C, "R5 read zero past window");

      // R8: power down
      wr(7'h40, 8'h40);
      check(pwr_down_o, "R8 pd set", {31'b0, pwr_down_o}, 1);
      rd_chk(7'h40, "R8 no drive in pd");
      wr(7'h40, 8'hE1);
      check(soft_seen == soft_exp, "R8 no soft reset in pd", soft_seen, soft_exp);
      wr(7'h40, 8'h21);
      check(!pwr_down_o && !led_shutter_o && !stay_awake_o, "R8 only bit 6",
            {29'b0, pwr_down_o, led_shutter_o, stay_awake_o}, 0);
      rd_chk(7'h40, "R8 readback after pd");

      // R4: broken transaction then resync
      partial(5);
      repeat (TOUT + 50) @(negedge clk);
      check(!sdio_oe, "R4 idle after timeout", {31'b0, sdio_oe}, 0);
      wr(7'h45, 8'h3C);
      rd_chk(7'h45, "R4 resync write/read");
      partial(12);
      repeat (TOUT + 50) @(negedge clk);
      rd_chk(7'h41, "R4 resync after long partial");

      // random traffic
      for (int n = 0; n < 150; n++) begin
         logic [6:0] a;
         int r;
         r = $urandom_range(0, 15);
         case (r)
            12:      a = 7'h77;
            13:      a = 7'h00;
            14:      a = 7'h4C;
            15:      a = 7'h3F;
            default: a = 7'h40 + 7'(r);
         endcase
         awake_i = $urandom_range(0, 1) == 1;
         if ($urandom_range(0, 1) == 1) begin
            wr(a, 8'($urandom_range(0, 255)));
            check(pwr_down_o == exp_cfg[6], "R8 pd output", {31'b0, pwr_down_o}, {31'b0, exp_cfg[6]});
         end else begin
            rd_chk(a, "R1 R10 random read");
         end
      end
      check(soft_seen == soft_exp, "R7 soft count", soft_seen, soft_exp);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule